// File: doc/BRIEF.md
# Floppy Controller Host Register and Byte Handshake

This block is the processor-facing side of a floppy disk formatter/controller. A two-bit address plus single-cycle read and write strobes reach four registers: status (read) / command (write), track, sector and data. It also owns the busy flag, the interrupt request and the byte-level data request (DRQ) handshake between the host and an external serializer. The serializer drives `rx_valid` when it has assembled a byte from the disk. It drives `tx_need` when it wants the next byte to write.

A separate command sequencer uses the block in three ways. It starts work on `cmd_go`. It reports the end of a command on `cmd_done`. While a read or write data command runs, it holds `xfer_active` high, with `xfer_write` giving the direction. Lost data is handled by direction. On a read, an overrun raises a sticky flag and the newer byte is kept. On a write, an underrun sends a zero byte and raises the same flag. The write gate stays off until the host has supplied the first byte.

Top module: `fdc_host_xfer`

## Requirements
- R1: A host read returns the status word at address 0, the track register at 1, the sector register at 2 and the data register at 3. A host write at address 0 loads the command register, which has no read path. A write at 1, 2 or 3 loads track, sector or data; the status word has no write path.
- R2: While reset is held, and in the cycle after it is released, the command register is 03 hex, the sector register 01 hex, track and data 00, and busy, intrq and drq are 0. The status word, including its not-ready bit 7, reads 00.
- R3: During a read transfer (`xfer_active`=1, `xfer_write`=0), `rx_valid` moves `rx_byte` into the data register and sets drq in the next cycle. A host read of address 3 clears drq in the next cycle, unless a new byte arrives in the same cycle.
- R4: If `rx_valid` arrives during a read transfer while drq is still set, the lost-data flag (status bit 2) is set and the data register takes the new byte.
- R5: During a write transfer, drq is set one cycle after `xfer_active` rises with `xfer_write`=1. A host write to address 3 clears it. When `tx_need` comes with drq clear, the data register appears on `tx_byte` in the next cycle and drq is set again.
- R6: When `tx_need` comes during a write transfer while drq is still set, `tx_byte` becomes 00 in the next cycle and the lost-data flag is set.
- R7: `wgate` is high only during a write transfer, and only after the host has written address 3 at least once since that transfer began.
- R8: intrq is set in the cycle after `cmd_done` arrives while busy. It is cleared after a status read or any write to address 0. A set condition in the same cycle takes priority.
- R9: A command write while not busy loads the command register, sets busy, pulses `cmd_go` for one cycle and clears drq and lost data. `cmd_done` clears busy.
- R10: A command write while busy is ignored unless its upper nibble is 1101 (force interrupt). A force interrupt is always accepted: it clears busy and drq, pulses `cmd_go`, leaves lost data unchanged, and sets intrq when its bit 3 is 1.
- R11: Status bit 0 is busy. Bit 1 is drq while `xfer_active` is 1 and 0 otherwise. Bit 2 is lost data. Bit 7 is not-ready, the inverse of `drive_ready` delayed by one cycle. Bits 6 to 3 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low master reset |
| host_addr | input | 2 | Register select |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Selected register, combinational from address |
| cmd_reg | output | 8 | Command register to the sequencer |
| cmd_go | output | 1 | One-cycle pulse when a command is accepted |
| cmd_done | input | 1 | Sequencer reports command completion |
| drive_ready | input | 1 | Drive ready level |
| xfer_active | input | 1 | A data read/write command is transferring bytes |
| xfer_write | input | 1 | Transfer direction, 1 = write to disk |
| rx_valid | input | 1 | Assembled byte ready from serializer |
| rx_byte | input | 8 | Assembled byte |
| tx_need | input | 1 | Serializer needs the next byte |
| tx_byte | output | 8 | Byte handed to the serializer |
| wgate | output | 1 | Write gate enable |
| drq | output | 1 | Data request |
| intrq | output | 1 | Interrupt request |
| busy | output | 1 | Command in progress |

## Verification
The assertions assume that the serializer raises `tx_need` only while `wgate` is high and `rx_valid` only while a read transfer is active. They also assume that `xfer_write` does not change in the middle of a transfer, and that the host never drives read and write strobes in the same cycle. The stimulus keeps to these rules. All host accesses come from one task that pulses a single strobe for one cycle. The transfer direction is set in the same step that raises `xfer_active`, and it stays fixed until the step that lowers it. The serializer strobes are only pulsed inside the matching transfer window, and a write-side `tx_need` is only pulsed after the first data load has opened the gate.

// File: rtl/fdc_host_xfer.sv
module fdc_host_xfer #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    host_addr,
  input  logic          host_rd,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic [DW-1:0] cmd_reg,
  output logic          cmd_go,
  input  logic          cmd_done,
  input  logic          drive_ready,
  input  logic          xfer_active,
  input  logic          xfer_write,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_byte,
  input  logic          tx_need,
  output logic [DW-1:0] tx_byte,
  output logic          wgate,
  output logic          drq,
  output logic          intrq,
  output logic          busy
);
  localparam logic [DW-1:0] CMD_RST = DW'(3);
  localparam logic [DW-1:0] SEC_RST = DW'(1);
  localparam logic [3:0]    FORCE_OP = 4'hD;

  logic [DW-1:0] cmd_q, trk_q, sec_q, dat_q, tx_q;
  logic busy_q, drq_q, lost_q, irq_q, nrdy_q, primed_q, wact_d, go_q;

  wire wr_cmd   = host_wr && host_addr == 2'd0;
  wire is_force = host_wdata[DW-1:DW-4] == FORCE_OP;
  wire accept   = wr_cmd && (!busy_q || is_force);
  wire rd_stat  = host_rd && host_addr == 2'd0;
  wire rd_dat   = host_rd && host_addr == 2'd3;
  wire wr_dat   = host_wr && host_addr == 2'd3;
  wire wact     = xfer_active && xfer_write;
  wire rx_ev    = xfer_active && !xfer_write && rx_valid;
  wire tx_ev    = wact && tx_need;
  wire wr_start = wact && !wact_d;
  wire done_ev  = cmd_done && busy_q;

  wire [DW-1:0] status = {nrdy_q, {(DW-4){1'b0}}, lost_q, drq_q && xfer_active, busy_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q    <= CMD_RST;
      trk_q    <= '0;
      sec_q    <= SEC_RST;
      dat_q    <= '0;
      tx_q     <= '0;
      busy_q   <= 1'b0;
      drq_q    <= 1'b0;
      lost_q   <= 1'b0;
      irq_q    <= 1'b0;
      nrdy_q   <= 1'b0;
      primed_q <= 1'b0;
      wact_d   <= 1'b0;
      go_q     <= 1'b0;
    end else begin
      nrdy_q <= !drive_ready;
      wact_d <= wact;
      go_q   <= accept;

      if (accept) begin
        cmd_q  <= host_wdata;
        busy_q <= !is_force;
      end else if (done_ev) begin
        busy_q <= 1'b0;
      end

      if (done_ev || (accept && is_force && host_wdata[3]))
        irq_q <= 1'b1;
      else if (wr_cmd || rd_stat)
        irq_q <= 1'b0;

      if (host_wr && host_addr == 2'd1) trk_q <= host_wdata;
      if (host_wr && host_addr == 2'd2) sec_q <= host_wdata;

      if (rx_ev)       dat_q <= rx_byte;
      else if (wr_dat) dat_q <= host_wdata;

      if (accept)                           drq_q <= 1'b0;
      else if (rx_ev || tx_ev || wr_start)  drq_q <= 1'b1;
      else if (rd_dat || wr_dat)            drq_q <= 1'b0;

      if (accept && !is_force)              lost_q <= 1'b0;
      else if ((rx_ev || tx_ev) && drq_q)   lost_q <= 1'b1;

      if (tx_ev) tx_q <= drq_q ? '0 : dat_q;

      if (!wact)       primed_q <= 1'b0;
      else if (wr_dat) primed_q <= 1'b1;
    end
  end

  always_comb begin
    case (host_addr)
      2'd0:    host_rdata = status;
      2'd1:    host_rdata = trk_q;
      2'd2:    host_rdata = sec_q;
      default: host_rdata = dat_q;
    endcase
  end

  assign cmd_reg = cmd_q;
  assign cmd_go  = go_q;
  assign tx_byte = tx_q;
  assign wgate   = wact && primed_q;
  assign drq     = drq_q;
  assign intrq   = irq_q;
  assign busy    = busy_q;
endmodule

// File: rtl/fdc_host_xfer_chk.sv
module fdc_host_xfer_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    host_addr,
  input logic          host_rd,
  input logic          host_wr,
  input logic [DW-1:0] host_wdata,
  input logic          xfer_active,
  input logic          xfer_write,
  input logic          rx_valid,
  input logic          tx_need,
  input logic          cmd_done,
  input logic [DW-1:0] cmd_reg,
  input logic [DW-1:0] tx_byte,
  input logic          wgate,
  input logic          drq,
  input logic          intrq,
  input logic          busy,
  input logic          lost
);
  AST_RX_SETS_DRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_active && !xfer_write && rx_valid && !host_wr) |=> drq); // R3

  AST_DATA_READ_CLEARS_DRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == 2'd3 && !xfer_write && !rx_valid) |=> !drq); // R3

  AST_OVERRUN_LOST: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_active && !xfer_write && rx_valid && drq && !host_wr) |=> lost); // R4

  AST_UNDERRUN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_active && xfer_write && tx_need && drq) |=> (tx_byte == '0 && lost)); // R6

  AST_WGATE_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wgate) |-> $past(host_wr && host_addr == 2'd3)); // R7

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intrq) |-> $past((cmd_done && busy) ||
                           (host_wr && host_addr == 2'd0 && host_wdata[DW-1:DW-4] == 4'hD))); // R8

  AST_STATUS_READ_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == 2'd0 && !cmd_done) |=> !intrq); // R8

  AST_BUSY_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && host_wr && host_addr == 2'd0 && host_wdata[DW-1:DW-4] != 4'hD) |=> $stable(cmd_reg)); // R10
endmodule

bind fdc_host_xfer fdc_host_xfer_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
  .host_wr(host_wr), .host_wdata(host_wdata), .xfer_active(xfer_active),
  .xfer_write(xfer_write), .rx_valid(rx_valid), .tx_need(tx_need),
  .cmd_done(cmd_done), .cmd_reg(cmd_reg), .tx_byte(tx_byte), .wgate(wgate),
  .drq(drq), .intrq(intrq), .busy(busy), .lost(lost_q)
);

// File: tb/fdc_host_xfer_test.sv
`timescale 1ns/1ps
module fdc_host_xfer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] host_addr = '0;
  logic host_rd = 1'b0, host_wr = 1'b0;
  logic [7:0] host_wdata = '0, host_rdata, cmd_reg, tx_byte, rx_byte = '0;
  logic cmd_go, cmd_done = 1'b0, drive_ready = 1'b0;
  logic xfer_active = 1'b0, xfer_write = 1'b0, rx_valid = 1'b0, tx_need = 1'b0;
  logic wgate, drq, intrq, busy;

  int checks = 0, fails = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  fdc_host_xfer uut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && host_rd) begin
      if (exp_q.size() == 0) chk("scoreboard underflow", 1, 0);
      else chk(tag_q.pop_front(), host_rdata, exp_q.pop_front());
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic neg();
    @(negedge clk);
  endtask

  task automatic host_read(logic [1:0] a, logic [7:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    host_addr = a; host_rd = 1'b1;
    step();
    host_rd = 1'b0;
  endtask

  task automatic host_write(logic [1:0] a, logic [7:0] d);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    step();
    host_wr = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) step();
    neg();
    host_addr = 2'd0;
    #1 chk("R2 status in reset", host_rdata, 8'h00);
    chk("R2 cmd reset", cmd_reg, 8'h03);
    chk("R2 flags reset", {busy, intrq, drq}, 3'b000);
    step();
    rst_n = 1'b1; drive_ready = 1'b1;
    neg();
    chk("R2 cmd after release", cmd_reg, 8'h03);
    host_read(2'd2, 8'h01, "R2 sector reset");
    host_read(2'd1, 8'h00, "R2 track reset");
    host_read(2'd0, 8'h00, "R11 idle status");

    host_write(2'd1, 8'h22);
    host_write(2'd2, 8'h05);
    host_read(2'd1, 8'h22, "R1 track readback");
    host_read(2'd2, 8'h05, "R1 sector readback");

    host_write(2'd0, 8'h88);
    neg();
    chk("R9 cmd_go", cmd_go, 1);
    chk("R9 busy set", busy, 1);
    chk("R1 cmd loaded", cmd_reg, 8'h88);
    host_read(2'd0, 8'h01, "R1 cmd not readable at addr 0");
    host_write(2'd0, 8'h18);
    neg();
    chk("R10 ignored cmd", cmd_reg, 8'h88);
    chk("R10 no go", cmd_go, 0);

    xfer_write = 1'b0; xfer_active = 1'b1;
    rx_byte = 8'h41; rx_valid = 1'b1; step(); rx_valid = 1'b0;
    neg();
    chk("R3 drq set", drq, 1);
    host_read(2'd0, 8'h03, "R11 status drq mirror");
    host_read(2'd3, 8'h41, "R3 data byte");
    neg();
    chk("R3 drq cleared", drq, 0);
    rx_byte = 8'h42; rx_valid = 1'b1; step();
    rx_byte = 8'h43; step(); rx_valid = 1'b0;
    host_read(2'd0, 8'h07, "R4 lost on overrun");
    host_read(2'd3, 8'h43, "R4 newer byte kept");

    cmd_done = 1'b1; xfer_active = 1'b0; step(); cmd_done = 1'b0;
    neg();
    chk("R9 busy cleared", busy, 0);
    chk("R8 intrq set", intrq, 1);
    host_read(2'd0, 8'h04, "R11 lost visible, drq hidden");
    neg();
    chk("R8 status read clears", intrq, 0);

    host_write(2'd0, 8'hD8);
    neg();
    chk("R10 force sets intrq", intrq, 1);
    chk("R10 force go", cmd_go, 1);
    host_read(2'd0, 8'h04, "R10 force keeps lost");
    host_write(2'd0, 8'hA8);
    neg();
    chk("R8 cmd write clears intrq", intrq, 0);
    host_read(2'd0, 8'h01, "R9 lost cleared by command");

    xfer_write = 1'b1; xfer_active = 1'b1; step();
    neg();
    chk("R5 first drq", drq, 1);
    chk("R7 no gate before load", wgate, 0);
    host_read(2'd0, 8'h03, "R11 write drq mirror");
    host_write(2'd3, 8'h5A);
    neg();
    chk("R5 load clears drq", drq, 0);
    chk("R7 gate after load", wgate, 1);
    tx_need = 1'b1; step(); tx_need = 1'b0;
    neg();
    chk("R5 byte out", tx_byte, 8'h5A);
    chk("R5 drq again", drq, 1);
    tx_need = 1'b1; step(); tx_need = 1'b0;
    neg();
    chk("R6 zero byte", tx_byte, 8'h00);
    host_read(2'd0, 8'h07, "R6 lost on underrun");

    host_write(2'd0, 8'hD0);
    neg();
    chk("R10 force clears busy", busy, 0);
    chk("R10 force clears drq", drq, 0);
    chk("R10 force no irq", intrq, 0);
    chk("R10 force loaded", cmd_reg, 8'hD0);
    xfer_active = 1'b0; xfer_write = 1'b0; step();
    neg();
    chk("R7 gate off", wgate, 0);

    host_write(2'd0, 8'h08);
    cmd_done = 1'b1;
    host_read(2'd0, 8'h01, "R8 status with done");
    cmd_done = 1'b0;
    neg();
    chk("R8 set wins", intrq, 1);

    drive_ready = 1'b0; step();
    host_read(2'd0, 8'h80, "R11 not ready");

    repeat (2) step();
    chk("scoreboard empty", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule